// File: doc/BRIEF.md
# Split-Field Radio Event Timer

This block is the time base a radio scheduler works from. A short in-period counter runs from zero up to a programmable period value and then starts again. Each time it restarts, a wide counter of completed periods steps by one. Together the two fields form one 40-bit timestamp with the period count in the upper bits.

A capture register takes a snapshot of the full timestamp when a frame-start or frame-end strobe arrives. A control bit picks which of the two strobes it follows. A set of compare units raises an event pulse in each cycle where the in-period field and the period count both equal a programmed pair. A scheduler uses these pulses to start reception or transmission, or to raise an interrupt.

Software reaches the block through a simple register port. Reading the low half of the timestamp freezes the upper half in a shadow register, so the two halves read in sequence always belong to the same instant.

Top module: `stmr_top`

## Requirements
- R1: After reset the in-period field, the period count, the capture register, the status register (address 6) and the control register (address 0) read as zero. The period register (address 1) reads all ones, and every compare event output is low.
- R2: While the run bit (control bit 0) is set, the in-period field (read at address 2) steps by one each cycle. In the cycle after it equals or exceeds the period register, it returns to 0 and the period count steps by one in that same cycle. While the run bit is clear, both fields hold their values.
- R3: The period count wraps from all ones to zero without setting any status bit.
- R4: A read strobe at address 2 copies the period count of that cycle into a shadow register, which is read at address 3. The shadow register changes on no other event, including a read at address 2 made without the read strobe.
- R5: The capture source is chosen by control bit 1: 0 selects the frame-start strobe and 1 selects the frame-end strobe. A strobe on the selected input stores the 40-bit time of that cycle. The low 16 bits are read at address 4 and the upper 24 bits at address 5. The strobe also sets status bit 0. A strobe on the unselected input changes neither the capture register nor the status register.
- R6: A capture that arrives while status bit 0 is still set overwrites the stored time and sets status bit 1 (overrun). Writing a 1 to a status bit clears it.
- R7: Compare unit k holds a 16-bit value at address 8+2k and a 24-bit value at address 9+2k, and is enabled by control bit 2+k. Its event output is high in exactly those cycles where the unit is enabled, the run bit is set, the in-period field equals the 16-bit value and the period count equals the 24-bit value. One cycle after an event, status bit 2+k is set. That bit is cleared by writing a 1 to it.
- R8: A write to address 2 loads the in-period field and a write to address 3 loads the period count. A load takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for the shadow latch) |
| addr | input | 4 | Register address |
| wdata | input | 24 | Register write data |
| rdata | output | 24 | Register read data, selected by addr without delay |
| frame_start | input | 1 | Start-of-frame strobe |
| frame_end | input | 1 | End-of-frame strobe |
| cmp_evt | output | 2 | Compare event pulses, one per compare unit |

## Verification
The counting assertions assume that a load and the run bit are the only things that move the two fields, so each one excludes cycles carrying a write to address 2 or 3. The bench makes all loads while the timer is stopped. The single-pulse behaviour of the compare events relies on the timestamp never repeating while the timer runs. The bench programs each period and start value and then lets the timer run freely, comparing every sampled value against time computed from the elapsed cycle count. Frame strobes are driven for exactly one cycle, except in the overrun case, where two arrive back to back.

// File: rtl/stmr_pkg.sv
`timescale 1ns/1ps
package stmr_pkg;
  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_TLO    = 2;
  localparam int A_THI    = 3;
  localparam int A_CLO    = 4;
  localparam int A_CHI    = 5;
  localparam int A_STAT   = 6;
  localparam int CMP_BASE = 8;
  // control and status bit positions
  localparam int B_RUN    = 0;
  localparam int B_SEL    = 1;
  localparam int B_VALID  = 0;
  localparam int B_OVR    = 1;
  localparam int B_CMP0   = 2;
endpackage

// File: rtl/stmr_timebase.sv
`timescale 1ns/1ps
module stmr_timebase #(
  parameter int LO_W = 16,
  parameter int HI_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [LO_W-1:0] period,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [LO_W-1:0] ld_val_lo,
  input  logic [HI_W-1:0] ld_val_hi,
  input  logic            latch,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi,
  output logic [HI_W-1:0] shadow,
  output logic            wrap_w
);
  // end of a period: at or beyond the programmed last value
  function automatic logic at_end(input logic [LO_W-1:0] cnt, input logic [LO_W-1:0] per);
    return cnt >= per;
  endfunction

  function automatic logic [LO_W-1:0] next_lo(input logic [LO_W-1:0] cnt, input logic [LO_W-1:0] per);
    return at_end(cnt, per) ? '0 : cnt + 1'b1;
  endfunction

  assign wrap_w = run && at_end(lo, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo     <= '0;
      hi     <= '0;
      shadow <= '0;
    end else begin
      if (ld_lo)    lo <= ld_val_lo;
      else if (run) lo <= next_lo(lo, period);
      if (ld_hi)       hi <= ld_val_hi;
      else if (wrap_w) hi <= hi + 1'b1;
      if (latch) shadow <= hi;
    end
  end

  // R2 and R3: wrap clears the low field and steps the count, modulo its width
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && !ld_lo && !ld_hi) |=> (lo == '0 && hi == $past(hi) + 1'b1));
  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_w && !ld_lo && !ld_hi) |=> (lo == $past(lo) + 1'b1 && $stable(hi)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> ($stable(lo) && $stable(hi)));
  a_r4_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(shadow));
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> lo == $past(ld_val_lo));
endmodule

// File: rtl/stmr_capture.sv
`timescale 1ns/1ps
module stmr_capture #(
  parameter int T_W = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           frame_end,
  input  logic           sel_end,
  input  logic [T_W-1:0] now,
  input  logic           clr_valid,
  input  logic           clr_ovr,
  output logic [T_W-1:0] cap,
  output logic           valid,
  output logic           ovr,
  output logic           cap_ev_w
);
  assign cap_ev_w = sel_end ? frame_end : frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap   <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (cap_ev_w) cap <= now;
      if (cap_ev_w)       valid <= 1'b1;
      else if (clr_valid) valid <= 1'b0;
      if (cap_ev_w && valid) ovr <= 1'b1;
      else if (clr_ovr)      ovr <= 1'b0;
    end
  end

  // R5: selected strobe stores the time of its cycle, otherwise hold
  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev_w |=> (cap == $past(now) && valid));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev_w |=> $stable(cap));
  // R6: a second capture before clearing marks overrun
  a_r6_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev_w && valid) |=> ovr);
endmodule

// File: rtl/stmr_compare.sv
`timescale 1ns/1ps
module stmr_compare #(
  parameter int LO_W = 16,
  parameter int HI_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [LO_W-1:0] wval_lo,
  input  logic [HI_W-1:0] wval_hi,
  input  logic            en,
  input  logic            run,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  input  logic            clr,
  output logic [LO_W-1:0] ref_lo,
  output logic [HI_W-1:0] ref_hi,
  output logic            evt,
  output logic            flag
);
  function automatic logic both_match(input logic [LO_W-1:0] a_lo, input logic [HI_W-1:0] a_hi,
                                      input logic [LO_W-1:0] b_lo, input logic [HI_W-1:0] b_hi);
    return (a_lo == b_lo) && (a_hi == b_hi);
  endfunction

  assign evt = en && run && both_match(lo, hi, ref_lo, ref_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_lo <= '0;
      ref_hi <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_lo) ref_lo <= wval_lo;
      if (wr_hi) ref_hi <= wval_hi;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R7: an event always leaves its sticky flag behind; clearing works when idle
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && clr) |=> !flag);
endmodule

// File: rtl/stmr_top.sv
`timescale 1ns/1ps
module stmr_top #(
  parameter int LO_W   = 16,
  parameter int HI_W   = 24,
  parameter int N_CMP  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   wdata,
  output logic [HI_W-1:0]   rdata,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [N_CMP-1:0]  cmp_evt
);
  import stmr_pkg::*;

  localparam int T_W    = LO_W + HI_W;
  localparam int CTRL_W = 2 + N_CMP;
  localparam int STAT_W = 2 + N_CMP;

  logic              run_q, sel_q;
  logic [N_CMP-1:0]  en_q;
  logic [LO_W-1:0]   period_q;
  logic [LO_W-1:0]   t_lo;
  logic [HI_W-1:0]   t_hi, t_shadow;
  logic              wrap_w, cap_ev_w;
  logic [T_W-1:0]    cap;
  logic              cap_valid, cap_ovr;
  logic [STAT_W-1:0] clr_stat;
  logic [N_CMP-1:0]  cmp_flag;
  logic [N_CMP-1:0][LO_W-1:0] cmp_lo;
  logic [N_CMP-1:0][HI_W-1:0] cmp_hi;
  logic              wr_ctrl, wr_period, wr_tlo, wr_thi, wr_stat, rd_tlo;

  always_comb begin
    wr_ctrl   = wr_en && (int'(addr) == A_CTRL);
    wr_period = wr_en && (int'(addr) == A_PERIOD);
    wr_tlo    = wr_en && (int'(addr) == A_TLO);
    wr_thi    = wr_en && (int'(addr) == A_THI);
    wr_stat   = wr_en && (int'(addr) == A_STAT);
    rd_tlo    = rd_en && (int'(addr) == A_TLO);
    clr_stat  = wr_stat ? wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      sel_q    <= 1'b0;
      en_q     <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl) {en_q, sel_q, run_q} <= wdata[CTRL_W-1:0];
      if (wr_period) period_q <= wdata[LO_W-1:0];
    end
  end

  stmr_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
    .ld_lo(wr_tlo), .ld_hi(wr_thi), .ld_val_lo(wdata[LO_W-1:0]), .ld_val_hi(wdata),
    .latch(rd_tlo), .lo(t_lo), .hi(t_hi), .shadow(t_shadow), .wrap_w(wrap_w)
  );

  stmr_capture #(.T_W(T_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .sel_end(sel_q), .now({t_hi, t_lo}),
    .clr_valid(clr_stat[B_VALID]), .clr_ovr(clr_stat[B_OVR]),
    .cap(cap), .valid(cap_valid), .ovr(cap_ovr), .cap_ev_w(cap_ev_w)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    stmr_compare #(.LO_W(LO_W), .HI_W(HI_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wr_en && (int'(addr) == CMP_BASE + 2*g)),
      .wr_hi(wr_en && (int'(addr) == CMP_BASE + 2*g + 1)),
      .wval_lo(wdata[LO_W-1:0]), .wval_hi(wdata),
      .en(en_q[g]), .run(run_q), .lo(t_lo), .hi(t_hi),
      .clr(clr_stat[B_CMP0+g]),
      .ref_lo(cmp_lo[g]), .ref_hi(cmp_hi[g]),
      .evt(cmp_evt[g]), .flag(cmp_flag[g])
    );
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_CTRL:   rdata = HI_W'({en_q, sel_q, run_q});
      A_PERIOD: rdata = HI_W'(period_q);
      A_TLO:    rdata = HI_W'(t_lo);
      A_THI:    rdata = t_shadow;
      A_CLO:    rdata = HI_W'(cap[LO_W-1:0]);
      A_CHI:    rdata = cap[T_W-1:LO_W];
      A_STAT:   rdata = HI_W'({cmp_flag, cap_ovr, cap_valid});
      default: begin
        for (int k = 0; k < N_CMP; k++) begin
          if (int'(addr) == CMP_BASE + 2*k)     rdata = HI_W'(cmp_lo[k]);
          if (int'(addr) == CMP_BASE + 2*k + 1) rdata = cmp_hi[k];
        end
      end
    endcase
  end

  // R5: a strobe on the unselected input leaves the capture state alone
  a_r5_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_ev_w && !wr_stat) |=> ($stable(cap) && $stable(cap_valid) && $stable(cap_ovr)));
  // R3: the period count rolling over touches no status bit
  a_r3_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && (&t_hi) && !cap_ev_w && !(|cmp_evt)) |=>
      ($stable(cap_valid) && $stable(cap_ovr) && $stable(cmp_flag)));
endmodule

// File: tb/stmr_top_test.sv
`timescale 1ns/1ps
module stmr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [23:0] wdata = 24'd0;
  logic [23:0] rdata;
  logic        frame_start = 1'b0, frame_end = 1'b0;
  logic [1:0]  cmp_evt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cyc0   = 0;
  int g_per  = 0;
  int g_h0   = 0;

  stmr_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .frame_start(frame_start),
    .frame_end(frame_end), .cmp_evt(cmp_evt)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // expected time k cycles after a run started from (0, g_h0)
  function automatic logic [39:0] etime(input int k);
    logic [15:0] lo;
    logic [23:0] hi;
    lo = 16'(k % (g_per + 1));
    hi = 24'(g_h0 + k / (g_per + 1));
    return {hi, lo};
  endfunction

  function automatic int now_k();
    return cyc - cyc0;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 24'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [23:0] v);
    addr = 4'(a);
    #1;
    v = rdata;
  endtask

  task automatic start(input int per, input int h0, input int ctrl);
    wr(0, ctrl & ~1);
    wr(1, per);
    wr(2, 0);
    wr(3, h0);
    wr(0, ctrl | 1);
    cyc0 = cyc; g_per = per; g_h0 = h0;
  endtask

  // latch-and-read sweep: lo directly, hi through the shadow
  task automatic sweep(input string tag, input int n);
    logic [23:0] v;
    int kk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1;
      rd(2, v);
      kk = now_k();
      chk({tag, " lo"}, 64'(v), 64'(etime(kk)[15:0]));
      @(negedge clk);
      rd_en = 1'b0;
      rd(3, v);
      chk({tag, " hi"}, 64'(v), 64'(etime(kk)[39:16]));
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] v, v2;
    int kc, kstop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2, v); chk("R1 time lo", 64'(v), 64'h0);
    rd(3, v); chk("R1 shadow", 64'(v), 64'h0);
    rd(1, v); chk("R1 period", 64'(v), 64'hFFFF);
    rd(0, v); chk("R1 ctrl", 64'(v), 64'h0);
    rd(6, v); chk("R1 status", 64'(v), 64'h0);
    rd(4, v); chk("R1 capture", 64'(v), 64'h0);
    chk("R1 events", 64'(cmp_evt), 64'h0);

    // R2 and R8: counting sweeps over several periods
    start(0, 0, 0);  sweep("R2 p0", 12);
    start(1, 0, 0);  sweep("R2 p1", 12);
    start(2, 7, 0);  sweep("R8 p2", 12);
    start(5, 0, 0);  sweep("R2 p5", 15);
    start(11, 3, 0); sweep("R2 p11", 15);

    // R2 hold when stopped
    wr(0, 0);
    kstop = now_k();
    rd(2, v);
    chk("R2 stop lo", 64'(v), 64'(etime(kstop)[15:0]));
    repeat (5) @(negedge clk);
    rd(2, v);
    chk("R2 hold lo", 64'(v), 64'(etime(kstop)[15:0]));

    // R3 silent wrap of the period count
    wr(6, 15);
    start(1, 24'hFFFFFE, 0);
    sweep("R3 wrap", 6);
    rd(6, v); chk("R3 status", 64'(v), 64'h0);

    // R4 shadow changes only on a strobed low read
    start(0, 0, 0);
    @(negedge clk);
    rd_en = 1'b1;
    rd(2, v);
    kc = now_k();
    @(negedge clk);
    rd_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd(2, v2);
      @(negedge clk);
      rd(3, v);
      chk("R4 shadow stable", 64'(v), 64'(etime(kc)[39:16]));
    end

    // R5 capture on frame start
    start(7, 3, 0);
    repeat (3) @(negedge clk);
    wr(6, 3);
    @(negedge clk); frame_start = 1'b1; kc = now_k();
    @(negedge clk); frame_start = 1'b0;
    rd(4, v); chk("R5 cap lo", 64'(v), 64'(etime(kc)[15:0]));
    rd(5, v); chk("R5 cap hi", 64'(v), 64'(etime(kc)[39:16]));
    rd(6, v); chk("R5 valid", 64'(v), 64'h1);
    // unselected strobe ignored
    wr(6, 3);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    rd(6, v); chk("R5 ignore status", 64'(v), 64'h0);
    rd(4, v); chk("R5 ignore cap", 64'(v), 64'(etime(kc)[15:0]));
    // frame end selected
    wr(0, 3);
    @(negedge clk); frame_end = 1'b1; kc = now_k();
    @(negedge clk); frame_end = 1'b0;
    rd(4, v); chk("R5 end lo", 64'(v), 64'(etime(kc)[15:0]));
    rd(5, v); chk("R5 end hi", 64'(v), 64'(etime(kc)[39:16]));

    // R6 back-to-back capture
    wr(0, 1);
    wr(6, 3);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); kc = now_k();
    @(negedge clk); frame_start = 1'b0;
    rd(4, v); chk("R6 later lo", 64'(v), 64'(etime(kc)[15:0]));
    rd(5, v); chk("R6 later hi", 64'(v), 64'(etime(kc)[39:16]));
    rd(6, v); chk("R6 overrun", 64'(v), 64'h3);
    wr(6, 3);
    rd(6, v); chk("R6 cleared", 64'(v), 64'h0);

    // R7 compare events, both units enabled
    wr(0, 0);
    wr(8, 2);  wr(9, 5);
    wr(10, 3); wr(11, 1);
    rd(8, v);  chk("R7 ref0 lo", 64'(v), 64'h2);
    rd(11, v); chk("R7 ref1 hi", 64'(v), 64'h1);
    wr(6, 15);
    start(3, 0, 4 | 8);
    for (int i = 0; i < 30; i++) begin
      #1;
      chk("R7 evt0", 64'(cmp_evt[0]), 64'(now_k() == 22));
      chk("R7 evt1", 64'(cmp_evt[1]), 64'(now_k() == 7));
      @(negedge clk);
    end
    rd(6, v); chk("R7 flags", 64'(v), 64'hC);
    wr(6, 12);
    rd(6, v); chk("R7 flags clear", 64'(v), 64'h0);
    // only unit 0 enabled
    start(3, 0, 4);
    for (int i = 0; i < 26; i++) begin
      #1;
      chk("R7 evt0 alone", 64'(cmp_evt[0]), 64'(now_k() == 22));
      chk("R7 evt1 disabled", 64'(cmp_evt[1]), 64'h0);
      @(negedge clk);
    end
    rd(6, v); chk("R7 flag0 only", 64'(v), 64'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule